// File: doc/BRIEF.md
# Privilege-Aware Interrupt Priority Selector

This block decides, each cycle, whether a hart must take an interrupt right now, which interrupt it takes, and which privilege level handles it. It receives the pending and enable vectors, a delegation mask, the current privilege level and the machine and supervisor global enable bits. The active set is the pending vector masked by the enable vector. The delegation mask splits the active set into a machine-level group and a supervisor-level group. Each group has its own rule that depends on the privilege level.

The machine group is evaluated first. The supervisor group is considered only when the machine group yields nothing. Inside a group the lowest-numbered active bit wins. The result is a take strobe, the winning index, and an XLEN-wide cause word with the interrupt flag in its top bit. With `REG_OUT` set, a register stage with synchronous active-low reset sits behind the selection logic. With it cleared, the outputs follow the inputs in the same cycle.

Top module: `irq_pri_select`

## Requirements
- R1: An interrupt line is a candidate only when its bit is set in both `pend_i` and `en_i`.
- R2: A candidate whose bit is clear in `deleg_i` belongs to the machine group. A candidate whose bit is set there belongs to the supervisor group.
- R3: The machine group may fire when `priv_i` is below machine (0 or 1), or when `priv_i` is machine (3) and `mie_i` is 1.
- R4: The supervisor group may fire when `priv_i` is user (0), or when `priv_i` is supervisor (1) and `sie_i` is 1. It never fires at machine level.
- R5: When the machine group may fire and has a candidate, it wins, even over a lower-numbered supervisor candidate.
- R6: Within the winning group, the lowest-numbered candidate bit is reported on `idx_o`.
- R7: When `take_o` is 1, `cause_o` has bit XLEN-1 set, carries `idx_o` in its low $clog2(XLEN) bits, and has every other bit zero.
- R8: When no group may fire, `take_o`, `idx_o` and `cause_o` are all zero.
- R9: With `REG_OUT`=1, outputs reflect the inputs sampled at the previous rising edge. A low `rst_n` at a rising edge clears all outputs.
- R10: `priv_i` uses user=0, supervisor=1, machine=3. Code 2 is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | XLEN | Pending interrupt bits |
| en_i | input | XLEN | Per-interrupt enable bits |
| deleg_i | input | XLEN | Delegation mask, 1 = supervisor group |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | Interrupt must be taken |
| idx_o | output | $clog2(XLEN) | Winning interrupt index |
| cause_o | output | XLEN | Cause word: flag in top bit, index in low bits |

## Verification
The bench targets the cases where the groups compete:
- A lower-numbered supervisor candidate against a machine candidate. A design that scans the whole active set would report the supervisor bit.
- Machine level with the machine enable cleared while supervisor candidates are active. A design that falls through to the supervisor group would fire.
- Supervisor level with both enables cleared. A design that applies the global enable regardless of level would wrongly suppress the machine group.
- Bit 31 alone, an enable mask that hides a pending bit, and an all-pending vector. These catch a priority encoder that picks the highest bit or ignores the mask.

The bench also checks the cause-word layout and the one-cycle registered latency.

// File: rtl/irq_sel_pkg.sv
// Package: shared privilege codes for the interrupt selector.
// Assumes a two-bit privilege field in which code 2 is unused.
package irq_sel_pkg;
    localparam logic [1:0] PRIV_USER  = 2'd0;
    localparam logic [1:0] PRIV_SUPER = 2'd1;
    localparam logic [1:0] PRIV_MACH  = 2'd3;
endpackage

// File: rtl/irq_lowbit_find.sv
// Finds the lowest set bit of a vector (count-trailing-zeros style).
// Assumes IW is wide enough to hold W-1. pos is 0 when hit is 0.
module irq_lowbit_find #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] pos
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) pos = IW'(i);
        end
    end

    // Any bit set in the vector.
    assign hit = |vec;
endmodule

// File: rtl/irq_level_gate.sv
// Decides whether interrupts aimed at privilege LEVEL may fire now.
// Assumes priv is never 2, so codes compare numerically.
module irq_level_gate #(
    parameter logic [1:0] LEVEL = 2'd3
) (
    input  logic [1:0] priv,
    input  logic       gbl_en,
    output logic       allow
);
    // Below the target level always allowed; at it only with the global enable.
    always_comb begin
        allow = (priv < LEVEL) || ((priv == LEVEL) && gbl_en);
    end
endmodule

// File: rtl/irq_pri_select.sv
// Top: privilege-aware interrupt priority selector.
// Splits the active interrupts into machine and delegated supervisor groups,
// gates each by its privilege rule, gives the machine group precedence and
// reports the lowest-numbered winner. REG_OUT=1 adds a synchronous
// active-low reset register stage on the outputs.
module irq_pri_select
    import irq_sel_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int IDXW   = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] en_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    output logic            take_o,
    output logic [IDXW-1:0] idx_o,
    output logic [XLEN-1:0] cause_o
);
    localparam int NGRP = 2;  // 0 = machine group, 1 = supervisor group
    localparam logic [1:0] GRP_LVL [NGRP] = '{PRIV_MACH, PRIV_SUPER};

    logic [XLEN-1:0] active;
    logic [XLEN-1:0] grp_vec [NGRP];
    logic [NGRP-1:0] grp_hit;
    logic [NGRP-1:0] grp_ok;
    logic [IDXW-1:0] grp_pos [NGRP];
    logic [NGRP-1:0] gbl;

    logic            nxt_take;
    logic [IDXW-1:0] nxt_idx;
    logic [XLEN-1:0] nxt_cause;

    // Candidate set and group split by the delegation mask.
    always_comb begin
        active     = pend_i & en_i;
        grp_vec[0] = active & ~deleg_i;
        grp_vec[1] = active & deleg_i;
    end

    assign gbl = {sie_i, mie_i};

    // One finder and one privilege gate per group.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        irq_lowbit_find #(.W(XLEN), .IW(IDXW)) u_find (
            .vec (grp_vec[g]),
            .hit (grp_hit[g]),
            .pos (grp_pos[g])
        );
        irq_level_gate #(.LEVEL(GRP_LVL[g])) u_gate (
            .priv   (priv_i),
            .gbl_en (gbl[g]),
            .allow  (grp_ok[g])
        );
    end

    // Machine group first; supervisor group only when machine yields nothing.
    always_comb begin
        nxt_take  = 1'b0;
        nxt_idx   = '0;
        nxt_cause = '0;
        if (grp_hit[0] && grp_ok[0]) begin
            nxt_take = 1'b1;
            nxt_idx  = grp_pos[0];
        end else if (grp_hit[1] && grp_ok[1]) begin
            nxt_take = 1'b1;
            nxt_idx  = grp_pos[1];
        end
        if (nxt_take) begin
            nxt_cause[XLEN-1]   = 1'b1;
            nxt_cause[IDXW-1:0] = nxt_idx;
        end
    end

    if (REG_OUT) begin : g_reg
        // Output register with synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                take_o  <= 1'b0;
                idx_o   <= '0;
                cause_o <= '0;
            end else begin
                take_o  <= nxt_take;
                idx_o   <= nxt_idx;
                cause_o <= nxt_cause;
            end
        end
    end else begin : g_comb
        // Direct combinational outputs.
        always_comb begin
            take_o  = nxt_take;
            idx_o   = nxt_idx;
            cause_o = nxt_cause;
        end
    end
endmodule

// File: rtl/irq_pri_select_chk.sv
// Checker for irq_pri_select: relates outputs to the inputs they were
// derived from (delayed one cycle when REG_OUT=1).
module irq_pri_select_chk #(
    parameter int XLEN    = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int IDXW   = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pend_i,
    input logic [XLEN-1:0] en_i,
    input logic [XLEN-1:0] deleg_i,
    input logic [1:0]      priv_i,
    input logic            mie_i,
    input logic            sie_i,
    input logic            take_o,
    input logic [IDXW-1:0] idx_o,
    input logic [XLEN-1:0] cause_o
);
    logic [XLEN-1:0] v_act, v_deleg;
    logic [1:0]      v_priv;
    logic            v_mie, v_sie;
    logic [XLEN-1:0] low_mask;

    if (REG_OUT) begin : g_dly
        // Hold the inputs seen at the last edge, matching the output stage.
        always_ff @(posedge clk) begin
            v_act   <= pend_i & en_i;
            v_deleg <= deleg_i;
            v_priv  <= priv_i;
            v_mie   <= mie_i;
            v_sie   <= sie_i;
        end
    end else begin : g_now
        // Same-cycle view of the inputs.
        always_comb begin
            v_act   = pend_i & en_i;
            v_deleg = deleg_i;
            v_priv  = priv_i;
            v_mie   = mie_i;
            v_sie   = sie_i;
        end
    end

    // Bits below the reported index.
    assign low_mask = (XLEN'(1) << idx_o) - XLEN'(1);

    // R10
    priv_code_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_i != 2'd2);
    // R1
    winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> v_act[idx_o]);
    // R3
    mach_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !v_deleg[idx_o]) |-> (v_priv != 2'd3 || v_mie));
    // R4
    sup_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && v_deleg[idx_o]) |-> (v_priv == 2'd0 || (v_priv == 2'd1 && v_sie)));
    // R5
    mach_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && v_deleg[idx_o]) |-> ((v_act & ~v_deleg) == '0 || (v_priv == 2'd3 && !v_mie)));
    // R6
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((v_act & (v_deleg[idx_o] ? v_deleg : ~v_deleg) & low_mask) == '0));
    // R7
    cause_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cause_o[XLEN-1] && cause_o[IDXW-1:0] == idx_o
                    && $countones(cause_o) == $countones(idx_o) + 1));
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0 && idx_o == '0));
endmodule

bind irq_pri_select irq_pri_select_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend_i),
    .en_i    (en_i),
    .deleg_i (deleg_i),
    .priv_i  (priv_i),
    .mie_i   (mie_i),
    .sie_i   (sie_i),
    .take_o  (take_o),
    .idx_o   (idx_o),
    .cause_o (cause_o)
);

// File: tb/irq_pri_select_test.sv
`timescale 1ns/1ps
module irq_pri_select_test;
    localparam int XLEN = 32;
    localparam int IDXW = $clog2(XLEN);

    typedef struct packed {
        logic [31:0] pend;
        logic [31:0] en;
        logic [31:0] deleg;
        logic [1:0]  priv;
        logic        mie;
        logic        sie;
        logic        exp_take;
        logic [4:0]  exp_idx;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TAB [NV] = '{
        // R3/R6: machine level, enable set, lowest of 0x88
        '{32'h88, 32'hFF, 32'h0, 2'd3, 1'b1, 1'b0, 1'b1, 5'd3, 4'd3},
        // R3/R8: machine level, machine enable clear
        '{32'h88, 32'hFF, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 5'd0, 4'd3},
        // R3: supervisor level is below machine, enable ignored
        '{32'h88, 32'hFF, 32'h0, 2'd1, 1'b0, 1'b0, 1'b1, 5'd3, 4'd3},
        // R1: enable hides bit 1
        '{32'h22, 32'h20, 32'h0, 2'd3, 1'b1, 1'b0, 1'b1, 5'd5, 4'd1},
        // R2/R4: delegated, supervisor level with sie
        '{32'h22, 32'hFF, 32'h22, 2'd1, 1'b0, 1'b1, 1'b1, 5'd1, 4'd4},
        // R4: supervisor level, sie clear
        '{32'h22, 32'hFF, 32'h22, 2'd1, 1'b0, 1'b0, 1'b0, 5'd0, 4'd4},
        // R4: user level, always allowed
        '{32'h22, 32'hFF, 32'h22, 2'd0, 1'b0, 1'b0, 1'b1, 5'd1, 4'd4},
        // R4: supervisor group never at machine level
        '{32'h22, 32'hFF, 32'h22, 2'd3, 1'b1, 1'b1, 1'b0, 5'd0, 4'd4},
        // R5: machine bit 1 beats supervisor bit 0
        '{32'h3, 32'hFF, 32'h1, 2'd0, 1'b0, 1'b0, 1'b1, 5'd1, 4'd5},
        // R5: machine blocked, supervisor also blocked at machine level
        '{32'h3, 32'hFF, 32'h1, 2'd3, 1'b0, 1'b1, 1'b0, 5'd0, 4'd5},
        // R5: supervisor level, both enables clear: machine still fires
        '{32'h3, 32'hFF, 32'h1, 2'd1, 1'b0, 1'b0, 1'b1, 5'd1, 4'd5},
        // R6: only the top bit
        '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1, 5'd31, 4'd6},
        // R6: all pending, machine bit 0 only
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 2'd1, 1'b0, 1'b0, 1'b1, 5'd0, 4'd6},
        // R6: supervisor group lowest of 0xF0
        '{32'hF0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 1'b0, 1'b1, 1'b1, 5'd4, 4'd6},
        // R8: nothing enabled
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 2'd0, 1'b1, 1'b1, 1'b0, 5'd0, 4'd8}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [XLEN-1:0] pend_i, en_i, deleg_i;
    logic [1:0]      priv_i;
    logic            mie_i, sie_i;
    logic            take_o;
    logic [IDXW-1:0] idx_o;
    logic [XLEN-1:0] cause_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_pri_select #(.XLEN(XLEN), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
        .deleg_i(deleg_i), .priv_i(priv_i), .mie_i(mie_i), .sie_i(sie_i),
        .take_o(take_o), .idx_o(idx_o), .cause_o(cause_o)
    );

    function automatic logic [XLEN-1:0] mk_cause(input logic t, input logic [IDXW-1:0] i);
        logic [XLEN-1:0] c;
        c = '0;
        if (t) begin
            c[XLEN-1]   = 1'b1;
            c[IDXW-1:0] = i;
        end
        return c;
    endfunction

    task automatic check_out(input string tag, input logic t, input logic [IDXW-1:0] i);
        logic [XLEN-1:0] c;
        c = mk_cause(t, i);
        n_run++;
        if (take_o !== t || idx_o !== i || cause_o !== c) begin
            n_fail++;
            $display("FAIL %s: take=%0b idx=%0d cause=%h expected take=%0b idx=%0d cause=%h",
                     tag, take_o, idx_o, cause_o, t, i, c);
        end
    endtask

    task automatic drive(input logic [31:0] p, input logic [31:0] e, input logic [31:0] d,
                         input logic [1:0] pv, input logic m, input logic s);
        pend_i = p; en_i = e; deleg_i = d; priv_i = pv; mie_i = m; sie_i = s;
    endtask

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(32'hFF, 32'hFF, 32'h0, 2'd0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        // R9: reset clears outputs even with active inputs
        check_out("R9 reset", 1'b0, '0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(TAB[k].pend, TAB[k].en, TAB[k].deleg, TAB[k].priv, TAB[k].mie, TAB[k].sie);
            @(posedge clk);
            @(negedge clk);
            check_out($sformatf("R%0d row %0d", TAB[k].req, k), TAB[k].exp_take, TAB[k].exp_idx);
        end

        // R7: cause layout with a mid-range index
        drive(32'h0000_0400, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b1, 1'b0);
        @(posedge clk); @(negedge clk);
        check_out("R7 cause idx10", 1'b1, 5'd10);

        // R9: latency, new inputs not visible before the next edge
        drive(32'h0, 32'h0, 32'h0, 2'd3, 1'b1, 1'b0);
        #1;
        check_out("R9 hold before edge", 1'b1, 5'd10);
        @(posedge clk); @(negedge clk);
        check_out("R9 after edge", 1'b0, '0);

        // R9: mid-run synchronous reset clears a taken interrupt
        drive(32'h4, 32'h4, 32'h0, 2'd0, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        check_out("R2 pre-reset take", 1'b1, 5'd2);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check_out("R9 mid reset", 1'b0, '0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check_out("R10 user code after reset", 1'b1, 5'd2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule